// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sequences the stop modes of a small microcontroller. The CPU pulses a one-cycle strobe when it executes a stop instruction. In that same cycle the block samples five control bits: stop enable, debug enable, low-voltage-detect enable, low-voltage-detect-in-stop enable and partial power-down select. From these bits it either requests an illegal-opcode reset or moves into one of three stop states. The light states are left on any enabled interrupt. The deep state is left only by a low level on a dedicated wakeup pin.

On entry to deep stop the block freezes the I/O pin control bus. It also removes power from the core domain, and leaves each optional always-on domain (RTC, low-power oscillator, low-range crystal oscillator) powered only if its keep bit was set at entry. Leaving deep stop raises a one-cycle restart request. The pins stay frozen until software acknowledges the wakeup in run mode. The pullup of the wakeup pin always follows its own enable bit.

Top module: `stop_mode_ctrl`

## Requirements
- R1: A strobe with stop enable 0 raises `ill_rst_req` for exactly the next cycle and leaves `mode_stat` at run (2'b00).
- R2: A strobe with stop enable 1 and debug enable 1 gives `mode_stat` 2'b10 in the next cycle, whatever the other three bits are.
- R3: A strobe with stop enable 1, debug enable 0 and both low-voltage-detect bits 1 gives `mode_stat` 2'b10, whatever partial power-down select is.
- R4: A strobe with stop enable 1, debug enable 0 and either low-voltage-detect bit 0 gives `mode_stat` 2'b01 when partial power-down select is 0, and 2'b11 (deep) when it is 1.
- R5: The state leaves run only in the cycle after a strobe. Control bits, pin values and keep bits count only as sampled in the strobe cycle.
- R6: In deep stop, `pin_ctl_out` equals `pin_ctl_in` as sampled at the strobe and does not move. `core_pwr_en` is 0, and `dom_pwr_en[i]` equals keep bit i as sampled at the strobe (bit 0 RTC, bit 1 low-power oscillator, bit 2 low-range oscillator). Outside deep stop, `core_pwr_en` is 1 and every `dom_pwr_en` bit is 1.
- R7: In deep stop, `irq_pend` is ignored. When `wake_n` falls, it passes a two-stage synchronizer, and on the third rising edge after the fall `mode_stat` becomes run and `wake_rst_req` is 1 for one cycle.
- R8: After a deep wakeup, `pin_ctl_out` stays frozen until `pin_ack` is 1 at a rising edge in run. From the next cycle on it follows `pin_ctl_in` again.
- R9: In a light state (2'b01 or 2'b10), `irq_pend` high at a rising edge returns `mode_stat` to run in the next cycle with no `wake_rst_req`. A low `wake_n` has no effect there.
- R10: `wake_pu_en` equals `wake_pull_en` in every state. It is never forced on by deep stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_exec | input | 1 | One-cycle strobe: stop instruction executed |
| stop_en | input | 1 | Stop instruction allowed |
| dbg_en | input | 1 | Debug mode enabled |
| lvd_en | input | 1 | Low-voltage detect enabled |
| lvd_stop_en | input | 1 | Low-voltage detect kept on in stop |
| ppd_sel | input | 1 | Partial power-down select |
| irq_pend | input | 1 | Any enabled interrupt request |
| wake_n | input | 1 | Active-low wakeup pin, asynchronous |
| wake_pull_en | input | 1 | Pullup enable bit of the wakeup pin |
| pin_ack | input | 1 | Software acknowledge releasing frozen pins |
| keep_dom | input | 3 | Keep-powered bits for optional domains in deep stop |
| pin_ctl_in | input | 16 | Live pin control bus |
| pin_ctl_out | output | 16 | Pin control bus to the pads |
| core_pwr_en | output | 1 | Core domain power enable |
| dom_pwr_en | output | 3 | Optional domain power enables |
| wake_pu_en | output | 1 | Pullup enable driven to the wakeup pad |
| mode_stat | output | 2 | 00 run, 01 light, 10 light with regulator or debug, 11 deep |
| ill_rst_req | output | 1 | Illegal-opcode reset request pulse |
| wake_rst_req | output | 1 | Restart request pulse after deep wakeup |

## Verification
The hardest situation to reach is the window after a deep wakeup in which the pins are still frozen while live pin values and control bits have already moved on. The driver scrambles the control bits and pin bus right after every strobe. It then keeps the bus changing through the wakeup and holds off the acknowledge for a cycle, so the frozen value, the restart pulse and the release each show up at their own cycle. All 32 control-bit combinations are walked through this entry and exit sequence.

// File: rtl/stop_mode_pkg.sv
package stop_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN      = 2'b00,
    PM_LITE     = 2'b01,
    PM_LITE_ACT = 2'b10,
    PM_DEEP     = 2'b11
  } pm_state_e;

  typedef struct packed {
    logic stop_en;
    logic dbg_en;
    logic lvd_en;
    logic lvd_stop_en;
    logic ppd_sel;
  } pm_ctl_t;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pm_wake_sync.sv
module pm_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic low_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign sync_d[i] = pin_n;
      end else begin : g_next
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign low_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/pm_mode_decide.sv
module pm_mode_decide
  import stop_mode_pkg::*;
(
  input  pm_ctl_t   ctl,
  output pm_state_e target,
  output logic      illegal
);
  always_comb begin
    illegal = 1'b0;
    target  = PM_RUN;
    if (!ctl.stop_en) begin
      illegal = 1'b1;
    end else if (ctl.dbg_en) begin
      target = PM_LITE_ACT;
    end else if (ctl.lvd_en && ctl.lvd_stop_en) begin
      target = PM_LITE_ACT;
    end else if (ctl.ppd_sel) begin
      target = PM_DEEP;
    end else begin
      target = PM_LITE;
    end
  end
endmodule

// File: rtl/pm_pin_hold.sv
module pm_pin_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         release_i,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic         held
);
  logic         hold_q, hold_d;
  logic [W-1:0] lat_q;
  logic         lat_en;

  assign lat_en = capture && !hold_q;

  always_comb begin
    hold_d = hold_q;
    if (capture)        hold_d = 1'b1;
    else if (release_i) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= pin_in;
  end

  assign pin_out = hold_q ? lat_q : pin_in;
  assign held    = hold_q;

  // R6: frozen pins do not move while no release arrives
  p_pins_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !release_i) |=> (held && $stable(pin_out)));

  // R8: an acknowledge releases the pins in the next cycle
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && release_i && !capture) |=> (!held && pin_out == pin_in));
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import stop_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stop_exec,
  input  pm_state_e target,
  input  logic      illegal,
  input  logic      irq_pend,
  input  logic      wake_low,
  input  logic      pin_ack,
  output pm_state_e state_o,
  output logic      ill_req_o,
  output logic      wake_req_o,
  output logic      enter_deep,
  output logic      ack_release
);
  pm_state_e state_q, state_d;
  logic      ill_q, ill_d;
  logic      wrq_q, wrq_d;

  always_comb begin
    state_d = state_q;
    ill_d   = 1'b0;
    wrq_d   = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        if (stop_exec) begin
          if (illegal) ill_d   = 1'b1;
          else         state_d = target;
        end
      end
      PM_LITE, PM_LITE_ACT: begin
        if (irq_pend) state_d = PM_RUN;
      end
      PM_DEEP: begin
        if (wake_low) begin
          state_d = PM_RUN;
          wrq_d   = 1'b1;
        end
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      ill_q   <= 1'b0;
      wrq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ill_q   <= ill_d;
      wrq_q   <= wrq_d;
    end
  end

  assign enter_deep  = (state_q == PM_RUN) && stop_exec && !illegal && (target == PM_DEEP);
  assign ack_release = (state_q == PM_RUN) && pin_ack;
  assign state_o     = state_q;
  assign ill_req_o   = ill_q;
  assign wake_req_o  = wrq_q;

  // R1: refused stop gives one reset pulse and stays in run
  p_bad_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && stop_exec && illegal) |=> (ill_req_o && state_o == PM_RUN));

  // R5: no strobe, no departure from run
  p_strobe_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && !stop_exec) |=> (state_o == PM_RUN));

  // R7: deep stop ignores interrupts until the synchronized wakeup
  p_deep_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_DEEP && !wake_low) |=> (state_o == PM_DEEP && !wake_req_o));

  // R7: synchronized wakeup leaves deep stop with a restart pulse
  p_deep_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_DEEP && wake_low) |=> (state_o == PM_RUN && wake_req_o));

  // R9: light states return on an interrupt without restart
  p_light_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PM_LITE || state_q == PM_LITE_ACT) && irq_pend)
      |=> (state_o == PM_RUN && !wake_req_o));

  // R1: the two request pulses never coincide
  p_req_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ill_req_o && wake_req_o));
endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
  import stop_mode_pkg::*;
#(
  parameter int PIN_W     = 16,
  parameter int N_DOM     = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_exec,
  input  logic             stop_en,
  input  logic             dbg_en,
  input  logic             lvd_en,
  input  logic             lvd_stop_en,
  input  logic             ppd_sel,
  input  logic             irq_pend,
  input  logic             wake_n,
  input  logic             wake_pull_en,
  input  logic             pin_ack,
  input  logic [N_DOM-1:0] keep_dom,
  input  logic [PIN_W-1:0] pin_ctl_in,
  output logic [PIN_W-1:0] pin_ctl_out,
  output logic             core_pwr_en,
  output logic [N_DOM-1:0] dom_pwr_en,
  output logic             wake_pu_en,
  output logic [1:0]       mode_stat,
  output logic             ill_rst_req,
  output logic             wake_rst_req
);
  logic       srst_n;
  pm_ctl_t    ctl;
  pm_state_e  target, state;
  logic       illegal, wake_low, enter_deep, ack_release, held;
  logic [N_DOM-1:0] keep_q;

  assign ctl = '{stop_en: stop_en, dbg_en: dbg_en, lvd_en: lvd_en,
                 lvd_stop_en: lvd_stop_en, ppd_sel: ppd_sel};

  pm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(srst_n)
  );

  pm_wake_sync #(.STAGES(SYNC_STG)) u_wake (
    .clk(clk), .rst_n(srst_n), .pin_n(wake_n), .low_o(wake_low)
  );

  pm_mode_decide u_dec (
    .ctl(ctl), .target(target), .illegal(illegal)
  );

  pm_fsm u_fsm (
    .clk(clk), .rst_n(srst_n), .stop_exec(stop_exec), .target(target),
    .illegal(illegal), .irq_pend(irq_pend), .wake_low(wake_low),
    .pin_ack(pin_ack), .state_o(state), .ill_req_o(ill_rst_req),
    .wake_req_o(wake_rst_req), .enter_deep(enter_deep),
    .ack_release(ack_release)
  );

  pm_pin_hold #(.W(PIN_W)) u_pins (
    .clk(clk), .rst_n(srst_n), .capture(enter_deep), .release_i(ack_release),
    .pin_in(pin_ctl_in), .pin_out(pin_ctl_out), .held(held)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)         keep_q <= '0;
    else if (enter_deep) keep_q <= keep_dom;
  end

  assign core_pwr_en = (state != PM_DEEP);
  assign dom_pwr_en  = (state == PM_DEEP) ? keep_q : '1;
  assign wake_pu_en  = wake_pull_en;
  assign mode_stat   = state;

  // R6: deep stop always has frozen pins
  p_deep_pins_held_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (state == PM_DEEP) |-> held);

  // R6: optional domains in deep stop reflect keep bits taken at the strobe
  p_keep_taken_r6: assert property (@(posedge clk) disable iff (!srst_n)
    enter_deep |=> (dom_pwr_en == $past(keep_dom) && !core_pwr_en));
endmodule

// File: tb/stop_mode_ctrl_bench.sv
module stop_mode_ctrl_bench;
  localparam int PW = 16;
  localparam int ND = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_exec = 0, stop_en = 0, dbg_en = 0, lvd_en = 0, lvd_stop_en = 0, ppd_sel = 0;
  logic irq_pend = 0, wake_n = 1, wake_pull_en = 0, pin_ack = 0;
  logic [ND-1:0] keep_dom = '0;
  logic [PW-1:0] pin_ctl_in = '0;
  logic [PW-1:0] pin_ctl_out;
  logic core_pwr_en, wake_pu_en, ill_rst_req, wake_rst_req;
  logic [ND-1:0] dom_pwr_en;
  logic [1:0] mode_stat;

  stop_mode_ctrl u_stop_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_exec(stop_exec), .stop_en(stop_en),
    .dbg_en(dbg_en), .lvd_en(lvd_en), .lvd_stop_en(lvd_stop_en),
    .ppd_sel(ppd_sel), .irq_pend(irq_pend), .wake_n(wake_n),
    .wake_pull_en(wake_pull_en), .pin_ack(pin_ack), .keep_dom(keep_dom),
    .pin_ctl_in(pin_ctl_in), .pin_ctl_out(pin_ctl_out),
    .core_pwr_en(core_pwr_en), .dom_pwr_en(dom_pwr_en),
    .wake_pu_en(wake_pu_en), .mode_stat(mode_stat),
    .ill_rst_req(ill_rst_req), .wake_rst_req(wake_rst_req)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [1:0]    stat;
    logic          ill;
    logic          wrq;
    logic          held;
    logic [PW-1:0] pins;
    logic [ND-1:0] keep;
    string         req;
  } exp_t;

  exp_t q[$];
  int n_tests = 0;
  int n_fail  = 0;
  logic          hold_m = 1'b0;
  logic [PW-1:0] pins_m = '0;
  logic [ND-1:0] keep_m = '0;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [1:0] st, input logic il, input logic wr, input string r);
    exp_t e;
    e.stat = st; e.ill = il; e.wrq = wr; e.held = hold_m;
    e.pins = pins_m; e.keep = keep_m; e.req = r;
    q.push_back(e);
  endtask

  task automatic fail_line(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_fail++;
    $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
  endtask

  // monitor: pops expected items and compares them mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        logic [PW-1:0] pe;
        logic [ND-1:0] de;
        bit bad;
        e = q.pop_front();
        n_tests++;
        bad = 0;
        pe = e.held ? e.pins : pin_ctl_in;
        de = (e.stat == 2'b11) ? e.keep : '1;
        if (mode_stat != e.stat) begin fail_line(e.req, "mode_stat", 32'(mode_stat), 32'(e.stat)); bad = 1; end
        if (!bad && ill_rst_req != e.ill) begin fail_line(e.req, "ill_rst_req", 32'(ill_rst_req), 32'(e.ill)); bad = 1; end
        if (!bad && wake_rst_req != e.wrq) begin fail_line(e.req, "wake_rst_req", 32'(wake_rst_req), 32'(e.wrq)); bad = 1; end
        if (!bad && pin_ctl_out != pe) begin fail_line(e.req, "pin_ctl_out", 32'(pin_ctl_out), 32'(pe)); bad = 1; end
        if (!bad && core_pwr_en != (e.stat != 2'b11)) begin fail_line(e.req, "core_pwr_en", 32'(core_pwr_en), 32'(e.stat != 2'b11)); bad = 1; end
        if (!bad && dom_pwr_en != de) begin fail_line(e.req, "dom_pwr_en", 32'(dom_pwr_en), 32'(de)); bad = 1; end
        if (!bad && wake_pu_en != wake_pull_en) fail_line("R10", "wake_pu_en", 32'(wake_pu_en), 32'(wake_pull_en));
      end
    end
  end

  // expected mode from R1..R4; bits = {stop_en, dbg_en, lvd_en, lvd_stop_en, ppd_sel}
  function automatic logic [1:0] exp_mode(input logic [4:0] b);
    if (!b[4])             return 2'b00;
    if (b[3])              return 2'b10;
    if (b[2] && b[1])      return 2'b10;
    return b[0] ? 2'b11 : 2'b01;
  endfunction

  function automatic string req_of(input logic [4:0] b);
    if (!b[4])        return "R1";
    if (b[3])         return "R2";
    if (b[2] && b[1]) return "R3";
    return "R4";
  endfunction

  task automatic set_bits(input logic [4:0] b);
    {stop_en, dbg_en, lvd_en, lvd_stop_en, ppd_sel} = b;
  endtask

  task automatic run_case(input logic [4:0] b, input logic [PW-1:0] pv, input logic [ND-1:0] kv);
    logic [1:0] m;
    string r;
    m = exp_mode(b);
    r = req_of(b);
    set_bits(b);
    pin_ctl_in = pv;
    keep_dom = kv;
    wake_pull_en = b[0] ^ b[2];
    stop_exec = 1'b1;
    tick();
    stop_exec = 1'b0;
    // R5: scramble everything sampled at the strobe
    set_bits(~b);
    keep_dom = ~kv;
    if (m == 2'b11) begin
      hold_m = 1'b1; pins_m = pv; keep_m = kv;
    end
    pin_ctl_in = ~pv;
    push(m, (m == 2'b00), 1'b0, r);
    if (m == 2'b00) begin
      tick();
      push(2'b00, 1'b0, 1'b0, "R1 single pulse");
    end else if (m == 2'b11) begin
      irq_pend = 1'b1;
      pin_ctl_in = pv ^ 16'h5a5a;
      tick();
      push(2'b11, 1'b0, 1'b0, "R7 irq ignored in deep");
      irq_pend = 1'b0;
      wake_n = 1'b0;
      tick();
      push(2'b11, 1'b0, 1'b0, "R7 sync stage 1");
      tick();
      push(2'b11, 1'b0, 1'b0, "R7 sync stage 2");
      tick();
      push(2'b00, 1'b0, 1'b1, "R7 wake exit");
      wake_n = 1'b1;
      pin_ctl_in = 16'hc3c3 ^ pv;
      tick();
      push(2'b00, 1'b0, 1'b0, "R8 pins held after wake");
      pin_ack = 1'b1;
      tick();
      pin_ack = 1'b0;
      hold_m = 1'b0;
      push(2'b00, 1'b0, 1'b0, "R8 release on ack");
    end else begin
      wake_n = 1'b0;
      tick();
      push(m, 1'b0, 1'b0, "R9 wake ignored in light");
      wake_n = 1'b1;
      tick();
      tick();
      tick();
      irq_pend = 1'b1;
      tick();
      irq_pend = 1'b0;
      push(2'b00, 1'b0, 1'b0, "R9 irq exit");
    end
    tick();
    tick();
    tick();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) tick();
    push(2'b00, 1'b0, 1'b0, "reset state");
    tick();
    // R5: bits asking for deep but no strobe
    set_bits(5'b10001);
    pin_ctl_in = 16'h1234;
    tick(); tick(); tick();
    push(2'b00, 1'b0, 1'b0, "R5 no strobe no entry");
    tick();
    // directed cases
    run_case(5'b00001, 16'h0f0f, 3'b101);
    run_case(5'b11111, 16'h1111, 3'b010);
    run_case(5'b10110, 16'h2222, 3'b011);
    run_case(5'b10000, 16'h3333, 3'b001);
    run_case(5'b10101, 16'ha5c3, 3'b101);
    // every combination
    for (int i = 0; i < 32; i++) begin
      run_case(5'(i), 16'(i * 16'h0b31 + 16'h7001), 3'(i));
    end
    repeat (3) tick();
    finish_run();
  end
endmodule